// File: doc/BRIEF.md
# Byte Single-Error-Correcting Hamming Codec

This block protects one data byte with four check bits, forming a 12-bit codeword in which every position is numbered from 1 to 12. The check bits occupy the power-of-two positions. Each check bit is even parity over the positions whose number has the matching binary digit set. Because of this, recomputing the checks over a stored word gives a 4-bit syndrome, and that syndrome is the number of the position that flipped.

The block has two independent ports, each with one register stage. The encode port takes a byte with a valid strobe and returns the codeword one cycle later. The decode port takes a codeword with a valid strobe and, one cycle later, returns the repaired byte, the syndrome, an error flag, and a flag for syndromes that no single flip can produce. A write path uses the encode port in front of a storage array. A read path uses the decode port behind it.

Top module: `sec12_codec`

## Requirements
- R1: After reset, `encOutValid`, `decOutValid`, `encCode`, `decData`, `decErr`, `decUncorr` and `decSyndrome` are all zero.
- R2: Codeword bit `p-1` holds position `p`. Data bits 0 to 7 go, in that order, to positions 3, 5, 6, 7, 9, 10, 11 and 12.
- R3: Each check bit is even parity. Position 1 covers positions 3, 5, 7, 9 and 11. Position 2 covers positions 3, 6, 7, 10 and 11. Position 4 covers positions 5, 6, 7 and 12. Position 8 covers positions 9 to 12.
- R4: `encOutValid` is high in exactly the cycle after a cycle with `encValid` high, and it carries the codeword for that byte.
- R5: While `encValid` is low, `encCode` keeps its last value.
- R6: A valid codeword decodes to its byte with syndrome 0 and with `decErr` and `decUncorr` both low.
- R7: A codeword with one flipped position p (1 to 12) decodes to the original byte. The syndrome equals p, `decErr` is high and `decUncorr` is low.
- R8: A syndrome of 13, 14 or 15 raises both `decErr` and `decUncorr`. In that case no bit is inverted, and the byte is taken from the data positions as received.
- R9: `decOutValid` is high in exactly the cycle after a cycle with `decValid` high.
- R10: While `decValid` is low, `decData`, `decErr`, `decUncorr` and `decSyndrome` keep their last values.
- R11: The two ports work independently. When both are used in the same cycle, each one returns its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| encValid | input | 1 | Encode request strobe |
| encData | input | 8 | Byte to encode |
| encOutValid | output | 1 | Codeword ready |
| encCode | output | 12 | Codeword, bit p-1 is position p |
| decValid | input | 1 | Decode request strobe |
| decCode | input | 12 | Codeword to check and repair |
| decOutValid | output | 1 | Decode result ready |
| decData | output | 8 | Repaired byte |
| decErr | output | 1 | Syndrome was nonzero |
| decUncorr | output | 1 | Syndrome was 13 to 15 |
| decSyndrome | output | 4 | Recomputed check pattern |

## Verification
The encoder is given all-zero, all-one, single-bit, nibble and mixed bytes. These separate a wrong data placement from a wrong parity coverage, since each pattern turns on a different subset of the checks. Every such codeword is then decoded clean and with each of its 12 positions flipped in turn. This shows that every syndrome value from 1 to 12 points to the right position, for both data bits and check bits. Pairs of flips chosen to give syndromes 13, 14 and 15 exercise the uncorrectable path, where the byte must come through unrepaired. Idle cycles with changed inputs show that the results are held, and one cycle with both ports active shows that the ports do not interfere.

// File: rtl/sec12_pkg.sv
package sec12_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } sec12_strobe_t;
endpackage

// File: rtl/sec12_ctrl.sv
module sec12_ctrl
  import sec12_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          encValid,
  input  logic          decValid,
  output sec12_strobe_t strobe,
  output logic          encOutValid,
  output logic          decOutValid
);
  always_comb begin
    strobe.encLoad = encValid;
    strobe.decLoad = decValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      encOutValid <= 1'b0;
      decOutValid <= 1'b0;
    end else begin
      encOutValid <= encValid;
      decOutValid <= decValid;
    end
  end

  // R4: one-cycle encode latency
  assert_enc_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    encValid |=> encOutValid);
  assert_enc_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !encValid |=> !encOutValid);
  // R9: one-cycle decode latency
  assert_dec_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    decValid |=> decOutValid);
  assert_dec_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !decValid |=> !decOutValid);
endmodule

// File: rtl/sec12_datapath.sv
module sec12_datapath
  import sec12_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sec12_strobe_t       strobe,
  input  logic [DATA_W-1:0]   encData,
  input  logic [DATA_W+PAR_W-1:0] decCode,
  output logic [DATA_W+PAR_W-1:0] encCode,
  output logic [DATA_W-1:0]   decData,
  output logic                decErr,
  output logic                decUncorr,
  output logic [PAR_W-1:0]    decSyndrome
);
  localparam int CODE_W = DATA_W + PAR_W;

  // Scatter data bits into non-power-of-two positions
  function automatic logic [CODE_W-1:0] spreadData(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] w;
    int j;
    w = '0;
    j = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        w[p-1] = d[j];
        j++;
      end
    end
    return w;
  endfunction

  // Gather data bits back out of a codeword
  function automatic logic [DATA_W-1:0] gatherData(input logic [CODE_W-1:0] w);
    logic [DATA_W-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[j] = w[p-1];
        j++;
      end
    end
    return d;
  endfunction

  // XOR of position numbers' bit k over all set positions
  function automatic logic [PAR_W-1:0] checkOf(input logic [CODE_W-1:0] w);
    logic [PAR_W-1:0] s;
    s = '0;
    for (int k = 0; k < PAR_W; k++) begin
      for (int p = 1; p <= CODE_W; p++) begin
        if (((p >> k) & 1) == 1) s[k] = s[k] ^ w[p-1];
      end
    end
    return s;
  endfunction

  // Encode side
  logic [CODE_W-1:0] encWord;
  always_comb begin
    logic [PAR_W-1:0] parity;
    encWord = spreadData(encData);
    parity  = checkOf(encWord);
    for (int k = 0; k < PAR_W; k++) begin
      encWord[(1 << k) - 1] = parity[k];
    end
  end

  // Decode side
  logic [PAR_W-1:0]  synNow;
  logic              fixable;
  logic              overRange;
  logic [CODE_W-1:0] fixedWord;
  always_comb begin
    synNow    = checkOf(decCode);
    overRange = int'(synNow) > CODE_W;
    fixable   = (synNow != '0) && !overRange;
    fixedWord = decCode;
    if (fixable) fixedWord[int'(synNow) - 1] = ~decCode[int'(synNow) - 1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      encCode <= '0;
    end else if (strobe.encLoad) begin
      encCode <= encWord;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decData     <= '0;
      decErr      <= 1'b0;
      decUncorr   <= 1'b0;
      decSyndrome <= '0;
    end else if (strobe.decLoad) begin
      decData     <= gatherData(fixedWord);
      decErr      <= synNow != '0;
      decUncorr   <= overRange;
      decSyndrome <= synNow;
    end
  end

  // R3: every encoded word has a clean check pattern
  assert_enc_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.encLoad |=> checkOf(encCode) == '0);
  // R2: data positions of the codeword carry the byte
  assert_enc_place_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.encLoad |=> gatherData(encCode) == $past(encData));
  // R5: encode result held while idle
  assert_enc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.encLoad |=> $stable(encCode));
  // R8: uncorrectable always implies error
  assert_uncorr_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    decUncorr |-> decErr);
  // R6: zero syndrome never flags an error
  assert_zero_syn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (decSyndrome == '0) |-> !decErr);
  // R10: decode result held while idle
  assert_dec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.decLoad |=> $stable(decData) && $stable(decSyndrome) && $stable(decErr));
endmodule

// File: rtl/sec12_codec.sv
module sec12_codec
  import sec12_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    encValid,
  input  logic [DATA_W-1:0]       encData,
  output logic                    encOutValid,
  output logic [DATA_W+PAR_W-1:0] encCode,
  input  logic                    decValid,
  input  logic [DATA_W+PAR_W-1:0] decCode,
  output logic                    decOutValid,
  output logic [DATA_W-1:0]       decData,
  output logic                    decErr,
  output logic                    decUncorr,
  output logic [PAR_W-1:0]        decSyndrome
);
  sec12_strobe_t strobe;

  sec12_ctrl uCtrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .encValid    (encValid),
    .decValid    (decValid),
    .strobe      (strobe),
    .encOutValid (encOutValid),
    .decOutValid (decOutValid)
  );

  sec12_datapath #(.DATA_W(DATA_W), .PAR_W(PAR_W)) uPath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .encData     (encData),
    .decCode     (decCode),
    .encCode     (encCode),
    .decData     (decData),
    .decErr      (decErr),
    .decUncorr   (decUncorr),
    .decSyndrome (decSyndrome)
  );
endmodule

// File: tb/tb_sec12_codec.sv
module tb_sec12_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        encValid = 1'b0;
  logic [7:0]  encData = '0;
  logic        encOutValid;
  logic [11:0] encCode;
  logic        decValid = 1'b0;
  logic [11:0] decCode = '0;
  logic        decOutValid;
  logic [7:0]  decData;
  logic        decErr;
  logic        decUncorr;
  logic [3:0]  decSyndrome;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sec12_codec dut (
    .clk(clk), .rst_n(rst_n),
    .encValid(encValid), .encData(encData),
    .encOutValid(encOutValid), .encCode(encCode),
    .decValid(decValid), .decCode(decCode),
    .decOutValid(decOutValid), .decData(decData),
    .decErr(decErr), .decUncorr(decUncorr), .decSyndrome(decSyndrome)
  );

  // {byte, codeword} worked out from R2 and R3
  localparam logic [19:0] VEC [7] = '{
    {8'h00, 12'h000},
    {8'hFF, 12'hF77},
    {8'h01, 12'h007},
    {8'h80, 12'h888},
    {8'h0F, 12'h07F},
    {8'hF0, 12'hF08},
    {8'hA5, 12'hA27}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doEncode(input logic [7:0] d);
    @(negedge clk);
    encValid = 1'b1; encData = d;
    @(negedge clk);
    encValid = 1'b0;
  endtask

  task automatic doDecode(input logic [11:0] w);
    @(negedge clk);
    decValid = 1'b1; decCode = w;
    @(negedge clk);
    decValid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 encOutValid", 32'(encOutValid), 0);
    check("R1 decOutValid", 32'(decOutValid), 0);
    check("R1 encCode", 32'(encCode), 0);
    check("R1 decData", 32'(decData), 0);
    check("R1 flags", {30'b0, decErr, decUncorr}, 0);
    check("R1 decSyndrome", 32'(decSyndrome), 0);
    rst_n = 1'b1;

    // R4: nothing before the capturing edge
    @(negedge clk);
    encValid = 1'b1; encData = 8'h5A;
    #1 check("R4 no early valid", 32'(encOutValid), 0);
    @(negedge clk);
    encValid = 1'b0;
    check("R4 valid after one cycle", 32'(encOutValid), 1);
    @(negedge clk);
    check("R4 valid drops", 32'(encOutValid), 0);

    // Vector table: R2/R3 encode, R6 clean decode, R7 every single flip
    for (int i = 0; i < 7; i++) begin
      doEncode(VEC[i][19:12]);
      check("R2 R3 codeword", 32'(encCode), 32'(VEC[i][11:0]));
      check("R4 encOutValid", 32'(encOutValid), 1);
      doDecode(VEC[i][11:0]);
      check("R6 clean data", 32'(decData), 32'(VEC[i][19:12]));
      check("R6 clean flags", {26'b0, decSyndrome, decErr, decUncorr}, 0);
      check("R9 decOutValid", 32'(decOutValid), 1);
      for (int p = 1; p <= 12; p++) begin
        doDecode(VEC[i][11:0] ^ (12'h001 << (p - 1)));
        check("R7 repaired data", 32'(decData), 32'(VEC[i][19:12]));
        check("R7 syndrome", 32'(decSyndrome), 32'(p));
        check("R7 flags", {30'b0, decErr, decUncorr}, 32'b10);
      end
    end

    // R8: double flips landing on syndromes 13, 14, 15
    doDecode(12'h801);
    check("R8 syn13", 32'(decSyndrome), 13);
    check("R8 flags13", {30'b0, decErr, decUncorr}, 32'b11);
    check("R8 raw data13", 32'(decData), 32'h80);
    doDecode(12'h802);
    check("R8 syn14", 32'(decSyndrome), 14);
    check("R8 flags14", {30'b0, decErr, decUncorr}, 32'b11);
    check("R8 raw data14", 32'(decData), 32'h80);
    doDecode(12'h804);
    check("R8 syn15", 32'(decSyndrome), 15);
    check("R8 flags15", {30'b0, decErr, decUncorr}, 32'b11);
    check("R8 raw data15", 32'(decData), 32'h81);

    // R5 and R10: idle inputs change, outputs hold
    doEncode(8'hA5);
    doDecode(12'h007 ^ 12'h040);
    @(negedge clk);
    encData = 8'hFF; decCode = 12'h801;
    @(negedge clk);
    check("R5 encCode held", 32'(encCode), 32'hA27);
    check("R5 no encOutValid", 32'(encOutValid), 0);
    check("R10 decData held", 32'(decData), 32'h01);
    check("R10 syndrome held", 32'(decSyndrome), 7);
    check("R10 flags held", {30'b0, decErr, decUncorr}, 32'b10);
    check("R9 no decOutValid", 32'(decOutValid), 0);

    // R11: both ports in the same cycle
    @(negedge clk);
    encValid = 1'b1; encData = 8'h0F;
    decValid = 1'b1; decCode = 12'hF08 ^ 12'h100;
    @(negedge clk);
    encValid = 1'b0; decValid = 1'b0;
    check("R11 encCode", 32'(encCode), 32'h07F);
    check("R11 decData", 32'(decData), 32'hF0);
    check("R11 syndrome", 32'(decSyndrome), 9);
    check("R11 valids", {30'b0, encOutValid, decOutValid}, 32'b11);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule